// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches eight external interrupt pins and turns them into a single interrupt request with a vector index for a CPU core. Each pin has a two-bit sense code that selects low level, any change, falling edge or rising edge. Edge-sensed pins latch a pending flag. Level-sensed pins request only while the pin is low. A per-pin mask and a global interrupt enable gate every request. When several requests are active, the lowest pin number is served first.

Software reaches the mask, the two sense registers and the flag register through a byte-wide register port. Flags clear when a one is written to them. The core sets the global enable with `gie_set`, clears it with `gie_clr`, and takes an interrupt with `ack`. Taking an interrupt turns the global enable off and clears the served pin's flag. Pins 0 to 3 pass through a two-flop synchroniser, and pins 4 to 7 through a single sampling flop. Detection works on the pad value, so a pin driven as an output by the chip can raise a software-triggered interrupt.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the mask, both sense registers, every flag and the global enable read zero, and `irq` is low.
- R2: The register addresses are 0 = mask, 1 = sense for pins 3..0, 2 = sense for pins 7..4, 3 = flags. Pin p uses sense bits [2(p mod 4)+1 : 2(p mod 4)] of its register. Sense codes are 00 low level, 01 any change, 10 falling edge and 11 rising edge.
- R3: `irq` is high only when the global enable is set and at least one pin has both its mask bit set and a pending condition.
- R4: A pin with sense code 01 sets its flag on both edges. Code 10 sets the flag on a high-to-low change only, and code 11 on a low-to-high change only.
- R5: A pin with sense code 00 never sets its flag. It is pending exactly while its synchronised level is low.
- R6: An edge flag that sets while the global enable is off, or while the pin is masked, stays set. It raises `irq` once the enable and the mask allow it.
- R7: A write to address 3 clears each flag whose data bit is one and leaves every flag whose data bit is zero unchanged. An edge arriving in the same cycle wins over the clear.
- R8: When several requests are active, `irq_vec` gives the lowest pin number among them.
- R9: `ack` while `irq` is high clears the global enable and the flag of the pin in `irq_vec`. A later `gie_set` re-enables requests, which also allows nesting inside a handler.
- R10: Changing a pin's sense code can set its flag with no pin activity, for example going from falling to rising while the pin is high. The sequence mask, change the code, clear the flag, unmask leaves no request.
- R11: An edge sets the flag two clock edges after the pin changes on pins 4..7, and three clock edges after on pins 0..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | 8 | Pad levels of the interrupt pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational from `bus_addr`) |
| gie_set | input | 1 | Set the global enable (return from handler, or enable in software) |
| gie_clr | input | 1 | Clear the global enable |
| ack | input | 1 | Core takes the current interrupt |
| irq | output | 1 | Interrupt request |
| irq_vec | output | 3 | Index of the pin being requested |
| gie | output | 1 | Global enable state |

## Verification
The bench sweeps every pin through every sense code with both edge directions, so a detector that confuses rising with falling, or that latches a flag in level mode, shows up on a specific pin and code. It makes flags pend while the global enable is off and on two pins at once. A design that drops held flags, picks the higher pin, or clears the wrong flag on acknowledge then gives a wrong vector or a wrong flag byte. Writes of zero bytes and single-bit writes to the flag register catch a design that clears flags by plain assignment. A sense change from falling to rising on a high pin must create a flag, and the mask-then-clear sequence must leave `irq` low. An exact-cycle comparison of a lower and an upper pin catches a wrong synchroniser depth.

// File: rtl/eic_pkg.sv
package eic_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic [1:0] {
        REG_MASK     = 2'd0,
        REG_SENSE_LO = 2'd1,
        REG_SENSE_HI = 2'd2,
        REG_FLAG     = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/eic_detect.sv
module eic_detect import eic_pkg::*; #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   lvl,
    input  logic [2*W-1:0] sense,
    output logic [W-1:0]   set_vec,
    output logic [W-1:0]   low_vec,
    output logic [W-1:0]   is_level
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] arm;
    } det_t;

    det_t s_d, s_q;

    always_comb begin
        s_d.prev = lvl;
        for (int i = 0; i < W; i++) begin
            unique case (sense_e'(sense[2*i +: 2]))
                SENSE_LOW:  s_d.arm[i] = ~lvl[i];
                SENSE_ANY:  s_d.arm[i] = lvl[i] ^ s_q.prev[i];
                SENSE_FALL: s_d.arm[i] = ~lvl[i];
                default:    s_d.arm[i] = lvl[i];
            endcase
            is_level[i] = (sense_e'(sense[2*i +: 2]) == SENSE_LOW);
            set_vec[i]  = !is_level[i] && s_d.arm[i] && !s_q.arm[i];
            low_vec[i]  = is_level[i] && !lvl[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/eic_prio.sv
module eic_prio #(
    parameter int W = 8,
    localparam int VW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          valid,
    output logic [VW-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = VW'(i);
            end
        end
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl import eic_pkg::*; #(
    parameter int NPINS     = 8,
    parameter int LO_PINS   = 4,
    parameter int LO_STAGES = 2,
    parameter int HI_STAGES = 1,
    localparam int VEC_W    = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    input  logic             gie_set,
    input  logic             gie_clr,
    input  logic             ack,
    output logic             irq,
    output logic [VEC_W-1:0] irq_vec,
    output logic             gie
);
    localparam int HI_PINS = NPINS - LO_PINS;

    typedef struct packed {
        logic [NPINS-1:0]   mask;
        logic [2*NPINS-1:0] sense;
        logic [NPINS-1:0]   flag;
        logic               gie;
    } st_t;

    st_t st_d, st_q;

    logic [NPINS-1:0] lvl, set_vec, low_vec, is_level, pend, req, clr_wr, clr_ack;
    logic             take;

    eic_sync #(.W(LO_PINS), .STAGES(LO_STAGES)) u_sync_lo (
        .clk(clk), .rst_n(rst_n), .din(pin_in[LO_PINS-1:0]), .dout(lvl[LO_PINS-1:0]));

    eic_sync #(.W(HI_PINS), .STAGES(HI_STAGES)) u_sync_hi (
        .clk(clk), .rst_n(rst_n), .din(pin_in[NPINS-1:LO_PINS]), .dout(lvl[NPINS-1:LO_PINS]));

    eic_detect #(.W(NPINS)) u_det (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .sense(st_q.sense),
        .set_vec(set_vec), .low_vec(low_vec), .is_level(is_level));

    assign pend = low_vec | (st_q.flag & ~is_level);
    assign req  = pend & st_q.mask & {NPINS{st_q.gie}};

    eic_prio #(.W(NPINS)) u_prio (.req(req), .valid(irq), .idx(irq_vec));

    assign take = ack && irq;
    assign gie  = st_q.gie;

    always_comb begin
        st_d    = st_q;
        clr_wr  = (bus_we && reg_addr_e'(bus_addr) == REG_FLAG) ? bus_wdata : '0;
        clr_ack = take ? (NPINS'(1) << irq_vec) : '0;
        if (bus_we) begin
            unique case (reg_addr_e'(bus_addr))
                REG_MASK:     st_d.mask               = bus_wdata;
                REG_SENSE_LO: st_d.sense[NPINS-1:0]   = bus_wdata;
                REG_SENSE_HI: st_d.sense[2*NPINS-1:NPINS] = bus_wdata;
                default:      ;
            endcase
        end
        st_d.flag = (st_q.flag & ~clr_wr & ~clr_ack) | set_vec;
        if (take || gie_clr) st_d.gie = 1'b0;
        else if (gie_set)    st_d.gie = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_addr_e'(bus_addr))
            REG_MASK:     bus_rdata = st_q.mask;
            REG_SENSE_LO: bus_rdata = st_q.sense[NPINS-1:0];
            REG_SENSE_HI: bus_rdata = st_q.sense[2*NPINS-1:NPINS];
            default:      bus_rdata = st_q.flag;
        endcase
    end

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie); // R3
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> st_q.mask[irq_vec]); // R3
    AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (req[irq_vec] && ((req & ((NPINS'(1) << irq_vec) - NPINS'(1))) == '0))); // R8
    AST_TAKE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !gie); // R9
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd3) |=>
        ((st_q.flag & $past(bus_wdata) & ~$past(set_vec)) == '0)); // R7
    AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag & ~$past(st_q.flag) & $past(is_level)) == '0); // R5
endmodule

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = 8'hFF;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       gie_set = 1'b0, gie_clr = 1'b0, ack = 1'b0;
    logic       irq, gie;
    logic [2:0] irq_vec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gie_set(gie_set), .gie_clr(gie_clr),
        .ack(ack), .irq(irq), .irq_vec(irq_vec), .gie(gie));

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_set();
        gie_set = 1'b1; @(negedge clk); gie_set = 1'b0; #1;
    endtask

    task automatic pulse_clr();
        gie_clr = 1'b1; @(negedge clk); gie_clr = 1'b0; #1;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0; #1;
    endtask

    task automatic set_sense(int p, logic [1:0] code);
        wr((p < 4) ? 2'd1 : 2'd2, 8'(code) << (2 * (p % 4)));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reg", d, 0);
        end
        chk("R1 irq", irq, 0);
        chk("R1 gie", gie, 0);

        // R2 R4 sweep: every pin, every edge code, both directions
        for (int p = 0; p < 8; p++) begin
            for (int m = 1; m < 4; m++) begin
                pin_in = 8'hFF;
                set_sense(p, 2'(m));
                rd((p < 4) ? 2'd1 : 2'd2, d);
                chk("R2 sense field", d, m << (2 * (p % 4)));
                tick(4);
                wr(2'd3, 8'hFF);
                pin_in[p] = 1'b0;
                tick(4);
                rd(2'd3, d);
                chk("R4 fall edge flag", d, (m == 1 || m == 2) ? (1 << p) : 0);
                wr(2'd3, 8'hFF);
                pin_in[p] = 1'b1;
                tick(4);
                rd(2'd3, d);
                chk("R4 rise edge flag", d, (m == 1 || m == 3) ? (1 << p) : 0);
                wr(2'd3, 8'hFF);
            end
            // R5 level mode
            set_sense(p, 2'b00);
            tick(4);
            wr(2'd3, 8'hFF);
            wr(2'd0, 8'(1 << p));
            pulse_set();
            pin_in[p] = 1'b0;
            tick(4);
            chk("R5 level irq", irq, 1);
            chk("R5 level vec", irq_vec, p);
            rd(2'd3, d);
            chk("R5 level no flag", d, 0);
            pin_in[p] = 1'b1;
            tick(4);
            chk("R5 level released", irq, 0);
            rd(2'd3, d);
            chk("R5 no flag after", d, 0);
            wr(2'd0, 8'h00);
            pulse_clr();
        end

        // R6 R8 R9 R3: two falling pins pend with gie off
        pin_in = 8'hFF;
        wr(2'd1, 8'h20);
        wr(2'd2, 8'h20);
        tick(4);
        wr(2'd3, 8'hFF);
        wr(2'd0, 8'h44);
        pin_in[2] = 1'b0; pin_in[6] = 1'b0;
        tick(4);
        chk("R6 held while gie off irq", irq, 0);
        rd(2'd3, d);
        chk("R6 flags held", d, 8'h44);
        pulse_set();
        chk("R6 served after enable", irq, 1);
        chk("R8 lowest vector", irq_vec, 2);
        pulse_ack();
        chk("R9 ack clears gie", gie, 0);
        chk("R9 irq off in handler", irq, 0);
        rd(2'd3, d);
        chk("R9 ack clears served flag", d, 8'h40);
        pulse_set();
        chk("R9 nested irq", irq, 1);
        chk("R9 next vector", irq_vec, 6);

        // R7 write-one-to-clear
        wr(2'd3, 8'h00);
        rd(2'd3, d);
        chk("R7 zero write keeps flags", d, 8'h40);
        wr(2'd3, 8'h04);
        rd(2'd3, d);
        chk("R7 other bit write keeps flag", d, 8'h40);
        wr(2'd3, 8'h40);
        rd(2'd3, d);
        chk("R7 one write clears", d, 0);
        chk("R7 irq gone", irq, 0);

        // R3 mask gating
        pin_in[6] = 1'b1; tick(4);
        pin_in[6] = 1'b0; tick(4);
        wr(2'd0, 8'h04);
        chk("R3 masked pin no irq", irq, 0);
        wr(2'd0, 8'h40);
        chk("R3 unmasked irq", irq, 1);
        wr(2'd0, 8'h00);
        pulse_clr();
        wr(2'd3, 8'hFF);

        // R10 spurious flag on sense change
        pin_in = 8'hFF;
        wr(2'd1, 8'h08);
        tick(4);
        wr(2'd3, 8'hFF);
        wr(2'd1, 8'h0C);
        tick(2);
        rd(2'd3, d);
        chk("R10 spurious flag appears", d, 8'h02);
        wr(2'd1, 8'h08);
        tick(2);
        wr(2'd3, 8'hFF);
        pulse_set();
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h0C);
        tick(2);
        wr(2'd3, 8'h02);
        wr(2'd0, 8'h02);
        tick(2);
        chk("R10 safe sequence no irq", irq, 0);
        rd(2'd3, d);
        chk("R10 safe sequence no flag", d, 0);
        wr(2'd0, 8'h00);
        pulse_clr();

        // R11 sampling depth: pin 0 three edges, pin 4 two edges
        wr(2'd1, 8'h02);
        wr(2'd2, 8'h02);
        tick(4);
        wr(2'd3, 8'hFF);
        bus_addr = 2'd3;
        pin_in[0] = 1'b0; pin_in[4] = 1'b0;
        tick(1);
        chk("R11 after one edge", bus_rdata, 8'h00);
        tick(1);
        chk("R11 upper after two edges", bus_rdata, 8'h10);
        tick(1);
        chk("R11 lower after three edges", bus_rdata, 8'h11);

        done = 1;
        summary();
        $finish;
    end
endmodule